// File: doc/BRIEF.md
# Boundary-Scan Instruction Path with Data-Register Selection

This block is the instruction side of a boundary-scan test port. A shift register sits between the serial test input and the serial test output. A shadow register behind it holds the instruction that is in force. Decode logic turns that instruction into a choice of data register and a set of test-mode controls. The capture, shift and update strobes come from an external port controller, which also drives a synchronous active-low reset. The block does not implement that controller, and it does not implement the boundary cells.

The block holds two data registers of its own: a one-bit bypass stage and a 32-bit device identification register. The identification register is built only when the `HAS_ID` parameter is set. The boundary register lives outside the block, and its serial output comes back in as an input. A select line from the controller picks whether the serial output carries the instruction path or the data path.

Top module: `scan_ir_select`

## Requirements
- R1: When `ir_capture` is high at a clock edge, the instruction shift register loads bit 0 = 1 and bit 1 = 0, and bit i+2 loads `status_in[i]`. Its bit 0 then shows on `scan_so` while `sel_ir` is high.
- R2: When `ir_shift` is high at a clock edge, the instruction shift register moves one place toward bit 0 and `tdi` enters at the top bit. After IR_W shifts it holds the word shifted in, with the first bit sent in bit 0.
- R3: `active_op` keeps its value through capture and shift cycles. It takes the shift-register contents only at an edge where `ir_update` is high.
- R4: A clock edge with `rst_n` low sets `active_op` to the identification code (default 4'b0010) when `HAS_ID` is set, and to all ones otherwise.
- R5: An all-ones instruction selects the bypass stage (`dr_pick` = 0). A data capture loads 0 into the stage, and each data shift passes `tdi` to `dr_so` one clock later.
- R6: An all-zeros instruction selects the boundary register (`dr_pick` = 2) and raises `pins_from_cells`.
- R7: With default codes, 0001 selects the boundary register with no mode asserted. 0100 selects the boundary register and raises `core_from_cells`. 0101 selects bypass and raises `pins_from_cells`. 0110 selects bypass and raises `pins_float`.
- R8: The identification code selects the ID register (`dr_pick` = 1). A data capture loads {version[3:0], part[15:0], maker[10:0], 1'b1}, and shifts then send it out on `dr_so`, bit 0 first.
- R9: Any code that is not decoded (for example 0011, 1000, 1010) selects bypass and asserts no mode.
- R10: A data register that is not selected keeps its contents while another register is captured or shifted.
- R11: When `sel_ir` is low, `scan_so` equals `dr_so`. When the boundary register is selected, `dr_so` follows `bnd_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset from the port controller |
| tdi | input | 1 | Serial test data in |
| sel_ir | input | 1 | High: serial output carries the instruction path |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift strobe |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data-register capture strobe |
| dr_shift | input | 1 | Data-register shift strobe |
| status_in | input | IR_W-2 | Status bits captured into the upper instruction bits |
| bnd_so | input | 1 | Serial output of the external boundary register |
| scan_so | output | 1 | Serial test data out |
| active_op | output | IR_W | Instruction in force |
| dr_so | output | 1 | Serial output of the selected data register |
| dr_pick | output | 2 | Selected data register: 0 bypass, 1 ID, 2 boundary |
| pins_from_cells | output | 1 | Output pins driven from boundary cells |
| core_from_cells | output | 1 | Core inputs driven from boundary cells |
| pins_float | output | 1 | Output pins placed in high impedance |

## Verification
The bench reads the captured instruction word bit by bit. A design that dropped the fixed 01 marker, or swapped it with the status bits, would send the wrong leading pattern. It watches `active_op` through the shift cycles, before update, so a shadow that followed the shift register would change early. It scans undecoded codes and the clamp and high-impedance codes to catch decoders that fall through to the boundary register. It also interrupts an ID-register scan with a bypass scan and then resumes the ID shifting without a new capture; a design that disturbed the unselected register would send the wrong ID bits after the interruption.

// File: rtl/scan_ir_pkg.sv
// Shared types for the instruction path: data-register choice and mode set.
package scan_ir_pkg;

    typedef enum logic [1:0] {
        PICK_BYPASS = 2'd0,
        PICK_IDENT  = 2'd1,
        PICK_BOUND  = 2'd2
    } dr_pick_e;

    typedef struct packed {
        dr_pick_e pick;
        logic     pins_from_cells;
        logic     core_from_cells;
        logic     pins_float;
    } op_ctrl_t;

endpackage

// File: rtl/scan_ir_reg.sv
// Instruction shift register plus shadow register.
// Assumes the controller never raises capture and shift together;
// capture wins if it does. Reset is synchronous, active low.
module scan_ir_reg #(
    parameter int unsigned          IR_W   = 4,
    parameter int unsigned          STAT_W = 2,
    parameter logic [IR_W-1:0]      RST_OP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic [STAT_W-1:0] status_in,
    output logic              ir_so,
    output logic [IR_W-1:0]   op_q
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] cap_word;

    // Capture word: fixed 01 marker in the low bits, status above it.
    generate
        if (IR_W > 2) begin : g_status
            assign cap_word = {status_in[IR_W-3:0], 2'b01};
        end else begin : g_nostatus
            assign cap_word = 2'b01;
        end
    endgenerate

    // Shift register: parallel capture or one step toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= cap_word;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Shadow register: takes the shifted word only on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= RST_OP;
        end else if (update) begin
            op_q <= sr_q;
        end
    end

    assign ir_so = sr_q[0];

    p_capture_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (sr_q[1:0] == 2'b01));

    p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !capture) |=> (sr_q[IR_W-1] == $past(tdi)));

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(op_q));

    p_shadow_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (op_q == $past(sr_q)));

    p_reset_op_r4: assert property (@(posedge clk)
        !rst_n |=> (op_q == RST_OP));

endmodule

// File: rtl/scan_ir_decode.sv
// Instruction decoder: maps the active instruction to a data-register
// choice and test-mode controls. All ones and all zeros are fixed codes;
// the other codes are parameters. Undecoded codes behave as bypass.
module scan_ir_decode
    import scan_ir_pkg::*;
#(
    parameter int unsigned     IR_W      = 4,
    parameter bit              HAS_ID    = 1'b1,
    parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010,
    parameter logic [IR_W-1:0] OP_SAMPLE = 4'b0001,
    parameter logic [IR_W-1:0] OP_INTEST = 4'b0100,
    parameter logic [IR_W-1:0] OP_CLAMP  = 4'b0101,
    parameter logic [IR_W-1:0] OP_HIGHZ  = 4'b0110
) (
    input  logic [IR_W-1:0] op,
    output op_ctrl_t        ctrl
);

    // Priority decode: fixed codes first, then parameter codes.
    always_comb begin
        ctrl.pick            = PICK_BYPASS;
        ctrl.pins_from_cells = 1'b0;
        ctrl.core_from_cells = 1'b0;
        ctrl.pins_float      = 1'b0;
        if (op == {IR_W{1'b1}}) begin
            ctrl.pick = PICK_BYPASS;
        end else if (op == {IR_W{1'b0}}) begin
            ctrl.pick            = PICK_BOUND;
            ctrl.pins_from_cells = 1'b1;
        end else if (op == OP_SAMPLE) begin
            ctrl.pick = PICK_BOUND;
        end else if (op == OP_INTEST) begin
            ctrl.pick            = PICK_BOUND;
            ctrl.core_from_cells = 1'b1;
        end else if (op == OP_CLAMP) begin
            ctrl.pick            = PICK_BYPASS;
            ctrl.pins_from_cells = 1'b1;
        end else if (op == OP_HIGHZ) begin
            ctrl.pick       = PICK_BYPASS;
            ctrl.pins_float = 1'b1;
        end else if (HAS_ID && (op == OP_IDCODE)) begin
            ctrl.pick = PICK_IDENT;
        end
    end

endmodule

// File: rtl/scan_dr_bank.sv
// Local data registers (bypass stage and optional 32-bit ID register)
// and the serial-output selector. Only the selected register reacts to
// capture and shift; the boundary register is external.
module scan_dr_bank
    import scan_ir_pkg::*;
#(
    parameter bit          HAS_ID  = 1'b1,
    parameter int unsigned ID_LEN  = 32,
    parameter logic [ID_LEN-1:0] ID_WORD = '1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tdi,
    input  logic     dr_capture,
    input  logic     dr_shift,
    input  dr_pick_e pick,
    input  logic     bnd_so,
    output logic     dr_so
);

    logic byp_q;
    logic id_bit;

    // Bypass stage: loads 0 on capture, passes tdi on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (pick == PICK_BYPASS) begin
            if (dr_capture) begin
                byp_q <= 1'b0;
            end else if (dr_shift) begin
                byp_q <= tdi;
            end
        end
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_LEN-1:0] id_q;

            // ID register: loads the constant word, shifts toward bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    id_q <= ID_WORD;
                end else if (pick == PICK_IDENT) begin
                    if (dr_capture) begin
                        id_q <= ID_WORD;
                    end else if (dr_shift) begin
                        id_q <= {tdi, id_q[ID_LEN-1:1]};
                    end
                end
            end

            assign id_bit = id_q[0];

            p_id_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (dr_capture && pick == PICK_IDENT) |=> (id_q == ID_WORD));

            p_keep_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (pick != PICK_IDENT) |=> $stable(id_q));
        end else begin : g_noid
            assign id_bit = 1'b0;
        end
    endgenerate

    // Serial output of whichever register is selected.
    always_comb begin
        unique case (pick)
            PICK_IDENT: dr_so = id_bit;
            PICK_BOUND: dr_so = bnd_so;
            default:    dr_so = byp_q;
        endcase
    end

    p_bypass_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_capture && pick == PICK_BYPASS) |=> (byp_q == 1'b0));

    p_bypass_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_shift && !dr_capture && pick == PICK_BYPASS) |=> (byp_q == $past(tdi)));

    p_keep_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pick != PICK_BYPASS) |=> $stable(byp_q));

endmodule

// File: rtl/scan_ir_select.sv
// Top of the instruction path: instruction register, decoder, local
// data registers and the serial output selector. Strobes come from an
// external port controller; the boundary register is external.
module scan_ir_select
    import scan_ir_pkg::*;
#(
    parameter int unsigned     IR_W       = 4,
    parameter bit              HAS_ID     = 1'b1,
    parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0010,
    parameter logic [IR_W-1:0] OP_SAMPLE  = 4'b0001,
    parameter logic [IR_W-1:0] OP_INTEST  = 4'b0100,
    parameter logic [IR_W-1:0] OP_CLAMP   = 4'b0101,
    parameter logic [IR_W-1:0] OP_HIGHZ   = 4'b0110,
    parameter logic [3:0]      ID_VERSION = 4'h3,
    parameter logic [15:0]     ID_PART    = 16'hA5C1,
    parameter logic [10:0]     ID_MAKER   = 11'h2B5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  tdi,
    input  logic                                  sel_ir,
    input  logic                                  ir_capture,
    input  logic                                  ir_shift,
    input  logic                                  ir_update,
    input  logic                                  dr_capture,
    input  logic                                  dr_shift,
    input  logic [((IR_W > 2) ? IR_W-2 : 1)-1:0]  status_in,
    input  logic                                  bnd_so,
    output logic                                  scan_so,
    output logic [IR_W-1:0]                       active_op,
    output logic                                  dr_so,
    output logic [1:0]                            dr_pick,
    output logic                                  pins_from_cells,
    output logic                                  core_from_cells,
    output logic                                  pins_float
);

    localparam int unsigned      STAT_W  = (IR_W > 2) ? IR_W - 2 : 1;
    localparam int unsigned      ID_LEN  = 32;
    localparam logic [IR_W-1:0]  RST_OP  = HAS_ID ? OP_IDCODE : {IR_W{1'b1}};
    localparam logic [ID_LEN-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    logic     ir_so;
    op_ctrl_t ctrl;

    scan_ir_reg #(
        .IR_W   (IR_W),
        .STAT_W (STAT_W),
        .RST_OP (RST_OP)
    ) u_ir (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdi       (tdi),
        .capture   (ir_capture),
        .shift     (ir_shift),
        .update    (ir_update),
        .status_in (status_in),
        .ir_so     (ir_so),
        .op_q      (active_op)
    );

    scan_ir_decode #(
        .IR_W      (IR_W),
        .HAS_ID    (HAS_ID),
        .OP_IDCODE (OP_IDCODE),
        .OP_SAMPLE (OP_SAMPLE),
        .OP_INTEST (OP_INTEST),
        .OP_CLAMP  (OP_CLAMP),
        .OP_HIGHZ  (OP_HIGHZ)
    ) u_dec (
        .op   (active_op),
        .ctrl (ctrl)
    );

    scan_dr_bank #(
        .HAS_ID  (HAS_ID),
        .ID_LEN  (ID_LEN),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .pick       (ctrl.pick),
        .bnd_so     (bnd_so),
        .dr_so      (dr_so)
    );

    // Outputs: decoded controls and the serial output path selector.
    assign dr_pick         = ctrl.pick;
    assign pins_from_cells = ctrl.pins_from_cells;
    assign core_from_cells = ctrl.core_from_cells;
    assign pins_float      = ctrl.pins_float;
    assign scan_so         = sel_ir ? ir_so : dr_so;

    p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pins_from_cells, core_from_cells, pins_float}));

    p_float_not_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pins_float |-> (dr_pick != PICK_BOUND));

endmodule

// File: tb/scan_ir_select_bench.sv
// Bench: decode table walked by one loop, then directed tests.
module scan_ir_select_bench;

    localparam int IR_W = 4;
    localparam logic [31:0] ID_EXP = {4'h3, 16'hA5C1, 11'h2B5, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tdi = 1'b0;
    logic sel_ir = 1'b1;
    logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0;
    logic [1:0] status_in = 2'b10;
    logic bnd_so = 1'b0;
    logic scan_so, dr_so, pins_from_cells, core_from_cells, pins_float;
    logic [IR_W-1:0] active_op;
    logic [1:0] dr_pick;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // {code[3:0], pick[1:0], pins_from_cells, core_from_cells, pins_float}
    localparam logic [8:0] VEC [10] = '{
        {4'b1111, 2'd0, 3'b000},
        {4'b0000, 2'd2, 3'b100},
        {4'b0001, 2'd2, 3'b000},
        {4'b0100, 2'd2, 3'b010},
        {4'b0101, 2'd0, 3'b100},
        {4'b0110, 2'd0, 3'b001},
        {4'b0010, 2'd1, 3'b000},
        {4'b0011, 2'd0, 3'b000},
        {4'b1000, 2'd0, 3'b000},
        {4'b1010, 2'd0, 3'b000}
    };

    always #5 clk = ~clk;

    scan_ir_select u_scan_ir_select (
        .clk(clk), .rst_n(rst_n), .tdi(tdi), .sel_ir(sel_ir),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .status_in(status_in),
        .bnd_so(bnd_so), .scan_so(scan_so), .active_op(active_op),
        .dr_so(dr_so), .dr_pick(dr_pick), .pins_from_cells(pins_from_cells),
        .core_from_cells(core_from_cells), .pins_float(pins_float)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic scan_ir(input logic [IR_W-1:0] code);
        ir_capture = 1'b1; step(); ir_capture = 1'b0;
        ir_shift = 1'b1;
        for (int i = 0; i < IR_W; i++) begin
            tdi = code[i];
            step();
        end
        ir_shift = 1'b0;
        ir_update = 1'b1; step(); ir_update = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [IR_W-1:0] held;
        #1;
        step(); step();
        // R4: reset state
        chk("R4 reset op", {28'd0, active_op}, 32'h2);
        chk("R4 reset pick", {30'd0, dr_pick}, 32'd1);
        rst_n = 1'b1;
        step();

        // R8: ID capture and shift-out after reset
        sel_ir = 1'b0;
        dr_capture = 1'b1; step(); dr_capture = 1'b0;
        dr_shift = 1'b1; tdi = 1'b0;
        for (int i = 0; i < 32; i++) begin
            chk("R8 id bit", {31'd0, dr_so}, {31'd0, ID_EXP[i]});
            step();
        end
        dr_shift = 1'b0;

        // Decode table (R5, R6, R7, R9)
        for (int k = 0; k < 10; k++) begin
            scan_ir(VEC[k][8:5]);
            chk("R2/R3 op loaded", {28'd0, active_op}, {28'd0, VEC[k][8:5]});
            chk("R5/R6/R7/R9 pick", {30'd0, dr_pick}, {30'd0, VEC[k][4:3]});
            chk("R6/R7/R9 modes", {29'd0, pins_from_cells, core_from_cells, pins_float},
                {29'd0, VEC[k][2:0]});
        end

        // R1: captured word 1001 shifted out bit 0 first; R3 hold during shift
        sel_ir = 1'b1;
        held = active_op;
        ir_capture = 1'b1; step(); ir_capture = 1'b0;
        ir_shift = 1'b1;
        for (int i = 0; i < IR_W; i++) begin
            tdi = 1'b1;
            chk("R1 capture bit", {31'd0, scan_so}, {31'd0, (4'b1001 >> i) & 4'b1});
            step();
            chk("R3 shadow holds", {28'd0, active_op}, {28'd0, held});
        end
        ir_shift = 1'b0;
        ir_update = 1'b1; step(); ir_update = 1'b0;
        chk("R3 update takes", {28'd0, active_op}, 32'hF);

        // R5: bypass capture 0, one-stage pass
        sel_ir = 1'b0;
        dr_capture = 1'b1; step(); dr_capture = 1'b0;
        chk("R5 bypass capture", {31'd0, dr_so}, 32'd0);
        dr_shift = 1'b1; tdi = 1'b1; step();
        chk("R5 bypass pass 1", {31'd0, dr_so}, 32'd1);
        tdi = 1'b0; step();
        chk("R5 bypass pass 0", {31'd0, dr_so}, 32'd0);
        dr_shift = 1'b0;
        chk("R11 scan_so follows dr", {31'd0, scan_so}, {31'd0, dr_so});

        // R10: interrupt ID scan with bypass scan, then resume
        scan_ir(4'b0010);
        sel_ir = 1'b0;
        dr_capture = 1'b1; step(); dr_capture = 1'b0;
        dr_shift = 1'b1;
        for (int i = 0; i < 5; i++) step();
        dr_shift = 1'b0;
        scan_ir(4'b1111);
        dr_capture = 1'b1; step(); dr_capture = 1'b0;
        dr_shift = 1'b1; tdi = 1'b1;
        for (int i = 0; i < 3; i++) step();
        dr_shift = 1'b0;
        scan_ir(4'b0010);
        dr_shift = 1'b1; tdi = 1'b0;
        for (int i = 5; i < 11; i++) begin
            chk("R10 id kept", {31'd0, dr_so}, {31'd0, ID_EXP[i]});
            step();
        end
        dr_shift = 1'b0;

        // R11: boundary selected, dr_so follows bnd_so
        scan_ir(4'b0001);
        sel_ir = 1'b0;
        bnd_so = 1'b1; #1;
        chk("R11 boundary so 1", {31'd0, scan_so}, 32'd1);
        bnd_so = 1'b0; #1;
        chk("R11 boundary so 0", {31'd0, dr_so}, 32'd0);

        // R4: reset mid-run restores the identification code
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R4 mid reset op", {28'd0, active_op}, 32'h2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule